// File: doc/BRIEF.md
# Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline. It picks the operands and the store data for the instruction now in execute. Each operand comes either from the register file read or from a result that an older, still-unretired instruction has produced. The unit keeps its own copy of the producer fields of the two older pipeline slots: the slot between execute and memory, and the slot between memory and write-back. For each consumer path it compares the source register specifier against the destination and write enable in those two slots. From that comparison it drives a 2-bit select and a multiplexer.

There are three consumer paths: ALU operand A, ALU operand B and the store-data input to memory. Operand A uses the first source specifier. Operand B and the store data both use the second. A load result does not exist until its memory access ends. An ALU consumer directly behind a load is therefore not served from the younger slot; that case is left to the stall logic outside this block. The store-data path is the exception: it can take the word the data memory returns in the same cycle. This lets a load feed the data of a store that follows it at once.

Top module: `fwd_unit`

## Requirements
- R1: After reset both producer slots are empty. Every select is 00 (register file), and opnd_a, opnd_b and store_data equal rf_rd1, rf_rd2 and rf_rd2.
- R2: The consumer may be one slot behind a non-load producer with write enable set, nonzero destination and a destination equal to the consumer's source specifier. That path then has select 10 and takes the producer's ALU result (the ex_result presented one cycle earlier).
- R3: The consumer may be two slots behind a producer with write enable set and a matching nonzero destination, with no forwarding from the younger slot. That path then has select 01 and takes the write-back value of that producer.
- R4: When both slots match the same source, the younger slot (one behind, select 10) wins over the older slot (select 01).
- R5: A producer with write enable clear, or with destination register 0, is never forwarded. A source specifier of 0 always gives select 00.
- R6: The value forwarded from the older slot is the loaded memory word (mem_rdata presented while the producer was in memory) for a load. For any other producer it is the ALU result.
- R7: A load in the younger slot is never forwarded to an ALU operand. sel_a and sel_b never show 10 or 11 for it, and the path falls back to the older slot or the register file.
- R8: When a load in the younger slot matches the second source, the store-data path has select 11 and store_data equals mem_rdata of the same cycle.
- R9: When no load in the younger slot matches, the store-data path follows the same select and value as operand B.
- R10: A producer three or more slots ahead no longer influences any path, and the select returns to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_rs1 | input | RW | First source specifier of the instruction in execute |
| ex_rs2 | input | RW | Second source specifier (operand B and store data) |
| rf_rd1 | input | XLEN | Register file value for ex_rs1 |
| rf_rd2 | input | XLEN | Register file value for ex_rs2 |
| ex_rd | input | RW | Destination of the instruction in execute |
| ex_we | input | 1 | Register write enable of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_result | input | XLEN | ALU result of the instruction in execute |
| mem_rdata | input | XLEN | Data memory read word for the instruction in memory |
| sel_a | output | 2 | Operand A select (00 rf, 01 write-back slot, 10 memory slot) |
| sel_b | output | 2 | Operand B select, same code |
| sel_st | output | 2 | Store-data select, same code plus 11 for memory read data |
| opnd_a | output | XLEN | Selected operand A |
| opnd_b | output | XLEN | Selected operand B |
| store_data | output | XLEN | Selected store data |

## Verification
Directed sequences place a consumer one, two and three slots behind a producer. Telling these apart separates the younger-slot path, the older-slot path and ageing out. A back-to-back pair of writers to the same register tells priority apart from mere matching. Load producers followed at once by a reader and by a store set the suppressed ALU path against the store path fed by the memory read. Writers with write enable clear or destination 0 show that matching is qualified. Random stimulus over a small register range then crowds collisions of every kind against a bench model of the two slots.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_WB = 2'b01,
        FWD_EM = 2'b10,
        FWD_LD = 2'b11
    } fwd_sel_e;
endpackage

// File: rtl/fwd_track.sv
module fwd_track #(
    parameter int XLEN = 32,
    parameter int RW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   ex_rd,
    input  logic            ex_we,
    input  logic            ex_is_load,
    input  logic [XLEN-1:0] ex_result,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            em_we,
    output logic [RW-1:0]   em_rd,
    output logic            em_ld,
    output logic [XLEN-1:0] em_res,
    output logic            wb_we,
    output logic [RW-1:0]   wb_rd,
    output logic [XLEN-1:0] wb_val
);
    typedef struct packed {
        logic            em_we;
        logic [RW-1:0]   em_rd;
        logic            em_ld;
        logic [XLEN-1:0] em_res;
        logic            wb_we;
        logic [RW-1:0]   wb_rd;
        logic            wb_from_mem;
        logic [XLEN-1:0] wb_alu;
        logic [XLEN-1:0] wb_ld;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.wb_we       = st_q.em_we;
        st_d.wb_rd       = st_q.em_rd;
        st_d.wb_from_mem = st_q.em_ld;
        st_d.wb_alu      = st_q.em_res;
        st_d.wb_ld       = mem_rdata;
        st_d.em_we       = ex_we;
        st_d.em_rd       = ex_rd;
        st_d.em_ld       = ex_is_load;
        st_d.em_res      = ex_result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign em_we  = st_q.em_we;
    assign em_rd  = st_q.em_rd;
    assign em_ld  = st_q.em_ld;
    assign em_res = st_q.em_res;
    assign wb_we  = st_q.wb_we;
    assign wb_rd  = st_q.wb_rd;
    assign wb_val = st_q.wb_from_mem ? st_q.wb_ld : st_q.wb_alu;

    // R6: a load leaving memory delivers the word read in that cycle
    p_wb_load_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_q.em_ld)) |-> (wb_val == $past(mem_rdata)));
endmodule

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int RW         = 5,
    parameter bit STORE_PATH = 1'b0
) (
    input  logic [RW-1:0] rs,
    input  logic          em_we,
    input  logic [RW-1:0] em_rd,
    input  logic          em_ld,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_rd,
    output fwd_sel_e      sel
);
    logic em_hit, wb_hit;

    always_comb begin
        em_hit = em_we && (em_rd != '0) && (em_rd == rs);
        wb_hit = wb_we && (wb_rd != '0) && (wb_rd == rs);
        sel    = FWD_RF;
        if (em_hit && !em_ld) begin
            sel = FWD_EM;
        end else if (em_hit && STORE_PATH) begin
            sel = FWD_LD;
        end else if (wb_hit) begin
            sel = FWD_WB;
        end
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fwd_sel_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] wb_val,
    input  logic [XLEN-1:0] em_val,
    input  logic [XLEN-1:0] ld_val,
    output logic [XLEN-1:0] out
);
    always_comb begin
        unique case (sel)
            FWD_WB:  out = wb_val;
            FWD_EM:  out = em_val;
            FWD_LD:  out = ld_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   ex_rs1,
    input  logic [RW-1:0]   ex_rs2,
    input  logic [XLEN-1:0] rf_rd1,
    input  logic [XLEN-1:0] rf_rd2,
    input  logic [RW-1:0]   ex_rd,
    input  logic            ex_we,
    input  logic            ex_is_load,
    input  logic [XLEN-1:0] ex_result,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [1:0]      sel_a,
    output logic [1:0]      sel_b,
    output logic [1:0]      sel_st,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] store_data
);
    localparam int NPATH    = 3;
    localparam int STORE_IX = NPATH - 1;

    logic            em_we, em_ld, wb_we;
    logic [RW-1:0]   em_rd, wb_rd;
    logic [XLEN-1:0] em_res, wb_val;

    logic [RW-1:0]   path_rs  [NPATH];
    logic [XLEN-1:0] path_rf  [NPATH];
    logic [XLEN-1:0] path_out [NPATH];
    fwd_sel_e        path_sel [NPATH];

    fwd_track #(.XLEN(XLEN), .RW(RW)) u_track (
        .clk(clk), .rst_n(rst_n),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
        .ex_result(ex_result), .mem_rdata(mem_rdata),
        .em_we(em_we), .em_rd(em_rd), .em_ld(em_ld), .em_res(em_res),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_val(wb_val)
    );

    assign path_rs[0] = ex_rs1;
    assign path_rs[1] = ex_rs2;
    assign path_rs[2] = ex_rs2;
    assign path_rf[0] = rf_rd1;
    assign path_rf[1] = rf_rd2;
    assign path_rf[2] = rf_rd2;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        fwd_match #(.RW(RW), .STORE_PATH(g == STORE_IX)) u_match (
            .rs(path_rs[g]),
            .em_we(em_we), .em_rd(em_rd), .em_ld(em_ld),
            .wb_we(wb_we), .wb_rd(wb_rd),
            .sel(path_sel[g])
        );
        fwd_mux #(.XLEN(XLEN)) u_mux (
            .sel(path_sel[g]),
            .rf_val(path_rf[g]), .wb_val(wb_val),
            .em_val(em_res), .ld_val(mem_rdata),
            .out(path_out[g])
        );
    end

    assign sel_a      = path_sel[0];
    assign sel_b      = path_sel[1];
    assign sel_st     = path_sel[2];
    assign opnd_a     = path_out[0];
    assign opnd_b     = path_out[1];
    assign store_data = path_out[2];

    // R2, R4: a non-load writer feeds the next reader from the younger slot
    p_young_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we && ex_rd != '0 && !ex_is_load) |=>
            (ex_rs1 != $past(ex_rd) || (sel_a == 2'b10 && opnd_a == $past(ex_result))));

    // R8: a load feeds the data of a store directly behind it
    p_store_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we && ex_rd != '0 && ex_is_load) |=>
            (ex_rs2 != $past(ex_rd) || (sel_st == 2'b11 && store_data == mem_rdata)));

    // R7: a load in the younger slot never reaches an ALU operand
    p_no_alu_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (em_ld && em_rd == ex_rs1) |-> (sel_a != 2'b10 && sel_a != 2'b11));

    // R5: register 0 is never forwarded
    p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs2 == '0) |-> (sel_b == 2'b00 && sel_st == 2'b00 && opnd_b == rf_rd2));
endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
    localparam int XLEN = 32;
    localparam int RW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [RW-1:0]   ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [XLEN-1:0] rf_rd1 = '0, rf_rd2 = '0, ex_result = '0, mem_rdata = '0;
    logic            ex_we = 1'b0, ex_is_load = 1'b0;
    logic [1:0]      sel_a, sel_b, sel_st;
    logic [XLEN-1:0] opnd_a, opnd_b, store_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench copy of the two producer slots, built from the requirements
    logic            m_em_we = 0, m_em_ld = 0, m_wb_we = 0;
    logic [RW-1:0]   m_em_rd = 0, m_wb_rd = 0;
    logic [XLEN-1:0] m_em_res = 0, m_wb_val = 0;

    always #4 clk = ~clk;

    fwd_unit #(.XLEN(XLEN), .NREG(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .rf_rd1(rf_rd1), .rf_rd2(rf_rd2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
        .ex_result(ex_result), .mem_rdata(mem_rdata),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .store_data(store_data)
    );

    function automatic logic [1:0] exp_sel(logic [RW-1:0] rs, bit store);
        logic em_hit, wb_hit;
        em_hit = m_em_we && m_em_rd != 0 && m_em_rd == rs;
        wb_hit = m_wb_we && m_wb_rd != 0 && m_wb_rd == rs;
        if (em_hit && !m_em_ld) return 2'b10;   // R2, R4
        if (em_hit && store)    return 2'b11;   // R8
        if (wb_hit)             return 2'b01;   // R3
        return 2'b00;                           // R1, R5, R7, R10
    endfunction

    function automatic logic [XLEN-1:0] exp_val(logic [1:0] s, logic [XLEN-1:0] rf);
        case (s)
            2'b01:   return m_wb_val;   // R6
            2'b10:   return m_em_res;
            2'b11:   return mem_rdata;
            default: return rf;
        endcase
    endfunction

    task automatic check(string req, string what, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        logic [1:0] ea, eb, es;
        ea = exp_sel(ex_rs1, 1'b0);
        eb = exp_sel(ex_rs2, 1'b0);
        es = exp_sel(ex_rs2, 1'b1);
        check(req, "sel_a", {30'd0, sel_a}, {30'd0, ea});
        check(req, "sel_b", {30'd0, sel_b}, {30'd0, eb});
        check(req, "sel_st", {30'd0, sel_st}, {30'd0, es});
        check(req, "opnd_a", opnd_a, exp_val(ea, rf_rd1));
        check(req, "opnd_b", opnd_b, exp_val(eb, rf_rd2));
        check(req, "store_data", store_data, exp_val(es, rf_rd2));
    endtask

    // one cycle: drive at the falling edge, check, then let the slots advance
    task automatic step(string req, logic [RW-1:0] rs1, logic [RW-1:0] rs2,
                        logic [RW-1:0] rd, bit we, bit ld,
                        logic [XLEN-1:0] res, logic [XLEN-1:0] mrd);
        @(negedge clk);
        ex_rs1 = rs1; ex_rs2 = rs2;
        rf_rd1 = 32'hF000_0000 | 32'(rs1);
        rf_rd2 = 32'hE000_0000 | 32'(rs2);
        ex_rd = rd; ex_we = we; ex_is_load = ld;
        ex_result = res; mem_rdata = mrd;
        #1;
        check_all(req);
        @(posedge clk);
        m_wb_we  = m_em_we;
        m_wb_rd  = m_em_rd;
        m_wb_val = m_em_ld ? mrd : m_em_res;
        m_em_we  = we; m_em_rd = rd; m_em_ld = ld; m_em_res = res;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        ex_rs1 = 5'd3; ex_rs2 = 5'd4; rf_rd1 = 32'h1111; rf_rd2 = 32'h2222; #1;
        check("R1", "sel_a", {30'd0, sel_a}, 32'd0);
        check("R1", "store_data", store_data, 32'h2222);
        check("R1", "opnd_a", opnd_a, 32'h1111);
        @(negedge clk);
        rst_n = 1'b1;

        // one, two and three slots behind
        step("R2",  0, 0, 5, 1, 0, 32'h11, 0);
        step("R2",  5, 5, 5, 1, 0, 32'h22, 0);
        step("R4",  5, 5, 0, 0, 0, 0, 0);
        step("R3",  5, 5, 0, 0, 0, 0, 0);
        step("R10", 5, 5, 0, 0, 0, 0, 0);
        // load then immediate reader and store
        step("R7",  0, 0, 7, 1, 1, 32'h100, 0);
        step("R8",  7, 7, 0, 0, 0, 0, 32'hABC);
        step("R6",  7, 7, 0, 0, 0, 0, 32'h999);
        // ALU op older slot, store follows operand B
        step("R9",  0, 0, 9, 1, 0, 32'h55, 0);
        step("R9",  0, 0, 0, 0, 0, 0, 0);
        step("R6",  9, 9, 0, 0, 0, 0, 32'h777);
        // load ahead of an older ALU writer of the same register
        step("R7",  0, 0, 6, 1, 0, 32'h66, 0);
        step("R7",  0, 0, 6, 1, 1, 32'h200, 0);
        step("R7",  6, 6, 0, 0, 0, 0, 32'hBEEF);
        // unqualified writers
        step("R5",  0, 0, 0, 1, 0, 32'h33, 0);
        step("R5",  0, 0, 3, 0, 0, 32'h44, 0);
        step("R5",  0, 3, 0, 0, 0, 0, 0);
        step("R5",  3, 0, 0, 0, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            step("R4", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                 5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 3) == 0), $urandom, $urandom);
        end
        done = 1'b1;
        summary();
    end
endmodule